// File: doc/BRIEF.md
# Indexed Register Port with Transmit Buffer

This block is the host-facing register side of a small Ethernet MAC model. The host sees only two bus locations. A write to the index location picks one internal register. Any later access to the data location reads or writes that register, until a new index is written. Reading the index location returns the latched index.

One special index makes the data location a streaming port into a byte-wide transmit buffer. Each data write stores one bus word there, least significant byte first, and moves the buffer pointer on. The word size follows a bus-width strap.

The host then loads a 16-bit frame length as two byte registers and sets a request bit. After a configurable delay the block retires the request and raises the completion flags. A self-timed soft reset and read-only identification bytes complete the map. Serialisation onto a medium is not part of this block. The medium side only reads the buffer through a separate byte port.

Top module: `ethIdxRegPort`

## Requirements
- R1: A write with `selData`=0 latches `wrData[7:0]` as the index. With `selData`=0, `rdData` returns the index. Every data access goes to the latched index until a new index is written. After reset the index is 0x00.
- R2: The identification registers are read-only. Index 0x28 returns `VENDOR_ID[7:0]`, index 0x29 returns `VENDOR_ID[15:8]`, index 0x2A returns 0x00 and index 0x2B returns 0x90. Data writes to these indices leave them unchanged.
- R3: Bits 7:6 of the interrupt status register (index 0xFE) are read-only and mirror `busMode`. The code 00 means 16-bit, 01 means 32-bit and 10 means 8-bit.
- R4: While the index is 0xF8, each data write stores one word into the buffer at the pointer, low byte first, and advances the pointer by the word size. The word size is 2 bytes for mode 00, 4 bytes for mode 01, and 1 byte for modes 10 and 11. The pointer reads at index 0xFA (low byte) and index 0xFB (high byte). Buffer byte n reads on `txRdData` when `txRdAddr`=n.
- R5: The pointer wraps modulo `BUF_BYTES`. A word that crosses the end of the buffer continues at byte 0 and sets the sticky overflow flag, which is bit 5 of index 0xFE.
- R6: The frame length is held in two read/write byte registers: index 0xFC holds the low byte and index 0xFD the high byte.
- R7: Writing 1 to bit 0 of index 0x02 starts a send and returns the buffer pointer to 0. The bit reads 1 for exactly `TX_DELAY` clock cycles after the write and then reads 0.
- R8: When a send completes, bit 1 of index 0xFE is set. Completions set the network status bits at index 0x01 in turn: bit 2 on the first completion and bit 3 on the next.
- R9: Bits 1 and 5 of index 0xFE and bits 2 and 3 of index 0x01 clear when a 1 is written to them. Writing 0 to them leaves them unchanged.
- R10: Writing 1 to bit 0 of index 0x00 starts a soft reset. The bit reads 1 for exactly `RST_CYCLES` cycles. The reset clears the length, the pointer, every status flag and any send in progress. Data writes during the reset are ignored.
- R11: Indices with no register read 0x00, and data writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 2 | Bus-width strap: 00 16-bit, 01 32-bit, 10 8-bit |
| wrEn | input | 1 | Write strobe for the location chosen by selData |
| selData | input | 1 | 0 selects the index location, 1 selects the data location |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data; a register reads zero-extended |
| txRdAddr | input | $clog2(BUF_BYTES) | Buffer read address for the medium side |
| txRdData | output | 8 | Buffer byte at txRdAddr |

## Verification
The register path is first driven with a table of index/data sequences. These cover identification reads, writes to read-only and absent indices, length writes and a short 16-bit stream. Together they separate a correct index latch from one that loses the index after a data access.

The buffer stream is then run in all four strap codes. Each mode's byte count shows in the pointer and in the buffer contents, so a wrong word size or byte order is exposed.

A 32-bit stream is driven across the end of the buffer, so wrap and overflow can be told apart from a plain advance. Two back-to-back sends and a soft reset with a write attempted in its window check the alternating end flags, the exact busy windows and the clearing behaviour.

// File: rtl/ethIdxPkg.sv
package ethIdxPkg;
  typedef logic [7:0] regIdx_t;

  localparam regIdx_t IDX_CTRL  = 8'h00;
  localparam regIdx_t IDX_NSTAT = 8'h01;
  localparam regIdx_t IDX_TXCTL = 8'h02;
  localparam regIdx_t IDX_VIDL  = 8'h28;
  localparam regIdx_t IDX_VIDH  = 8'h29;
  localparam regIdx_t IDX_PIDL  = 8'h2A;
  localparam regIdx_t IDX_PIDH  = 8'h2B;
  localparam regIdx_t IDX_MEMWR = 8'hF8;
  localparam regIdx_t IDX_PTRL  = 8'hFA;
  localparam regIdx_t IDX_PTRH  = 8'hFB;
  localparam regIdx_t IDX_LENL  = 8'hFC;
  localparam regIdx_t IDX_LENH  = 8'hFD;
  localparam regIdx_t IDX_ISTAT = 8'hFE;

  // Control to datapath strobes
  typedef struct packed {
    regIdx_t idx;
    logic    regWr;
    logic    memWr;
    logic    txStart;
    logic    txDone;
    logic    txBusy;
    logic    rstStart;
    logic    rstBusy;
  } strobe_t;

  function automatic logic [2:0] wordBytes(input logic [1:0] mode);
    case (mode)
      2'b00:   wordBytes = 3'd2;
      2'b01:   wordBytes = 3'd4;
      default: wordBytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/ethIdxCtrl.sv
module ethIdxCtrl
  import ethIdxPkg::*;
#(
  parameter int TX_DELAY   = 16,
  parameter int RST_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       selData,
  input  logic [7:0] wrByte,
  output strobe_t    stb
);
  localparam int TXW = $clog2(TX_DELAY + 1);
  localparam int RSW = $clog2(RST_CYCLES + 1);

  regIdx_t        idxQ;
  logic           txBusy, rstBusy;
  logic [TXW-1:0] txCnt;
  logic [RSW-1:0] rstCnt;
  logic           dataWr, txStart, txDone, rstStart, rstDone;

  assign dataWr   = wrEn && selData;
  assign rstStart = dataWr && (idxQ == IDX_CTRL) && wrByte[0] && !rstBusy;
  assign txStart  = dataWr && (idxQ == IDX_TXCTL) && wrByte[0] && !txBusy && !rstBusy;
  assign txDone   = txBusy && (txCnt == TXW'(TX_DELAY - 1));
  assign rstDone  = rstBusy && (rstCnt == RSW'(RST_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= IDX_CTRL;
    end else if (wrEn && !selData) begin
      idxQ <= wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (rstStart || txDone) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
    end else if (txBusy) begin
      txCnt <= txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstBusy <= 1'b0;
      rstCnt  <= '0;
    end else if (rstStart) begin
      rstBusy <= 1'b1;
      rstCnt  <= '0;
    end else if (rstDone) begin
      rstBusy <= 1'b0;
      rstCnt  <= '0;
    end else if (rstBusy) begin
      rstCnt <= rstCnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.idx      = idxQ;
    stb.regWr    = dataWr && !rstBusy;
    stb.memWr    = dataWr && !rstBusy && (idxQ == IDX_MEMWR);
    stb.txStart  = txStart;
    stb.txDone   = txDone;
    stb.txBusy   = txBusy;
    stb.rstStart = rstStart;
    stb.rstBusy  = rstBusy;
  end

  // R7
  tx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> txBusy);

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !txDone && !rstStart) |=> txBusy);

  // R10
  rst_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstStart |=> rstBusy);

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !selData) |=> $stable(idxQ));
endmodule

// File: rtl/ethIdxDatapath.sv
module ethIdxDatapath
  import ethIdxPkg::*;
#(
  parameter int          BUF_BYTES = 64,
  parameter logic [15:0] VENDOR_ID = 16'h1F5C
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [1:0]                   busMode,
  input  logic                         selData,
  input  logic [31:0]                  wrData,
  output logic [31:0]                  rdData,
  input  logic [$clog2(BUF_BYTES)-1:0] txRdAddr,
  output logic [7:0]                   txRdData
);
  localparam int PW = $clog2(BUF_BYTES);

  logic [7:0]    mem [BUF_BYTES];
  logic [PW-1:0] ptr;
  logic [PW:0]   ptrSum;
  logic [2:0]    nBytes;
  logic [7:0]    lenLo, lenHi, regByte;
  logic          isrPt, isrOvf, nsrEnd0, nsrEnd1, endSel;
  logic          wrIsr, wrNsr;

  assign nBytes = wordBytes(busMode);
  assign ptrSum = {1'b0, ptr} + (PW + 1)'(nBytes);
  assign wrIsr  = stb.regWr && (stb.idx == IDX_ISTAT);
  assign wrNsr  = stb.regWr && (stb.idx == IDX_NSTAT);

  always_ff @(posedge clk) begin
    if (stb.memWr && !stb.txStart) begin
      for (int b = 0; b < 4; b++) begin
        if (b < int'(nBytes)) mem[ptr + PW'(b)] <= wrData[8*b +: 8];
      end
    end
  end
  assign txRdData = mem[txRdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0; isrOvf <= 1'b0;
    end else if (stb.rstStart || stb.txStart) begin
      ptr <= '0;
      if (stb.rstStart) isrOvf <= 1'b0;
    end else begin
      if (stb.memWr) ptr <= ptrSum[PW-1:0];
      if (stb.memWr && ptrSum[PW]) isrOvf <= 1'b1;
      else if (wrIsr && wrData[5]) isrOvf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenLo <= '0; lenHi <= '0;
    end else if (stb.rstStart) begin
      lenLo <= '0; lenHi <= '0;
    end else if (stb.regWr) begin
      if (stb.idx == IDX_LENL) lenLo <= wrData[7:0];
      if (stb.idx == IDX_LENH) lenHi <= wrData[7:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrPt <= 1'b0; nsrEnd0 <= 1'b0; nsrEnd1 <= 1'b0; endSel <= 1'b0;
    end else if (stb.rstStart) begin
      isrPt <= 1'b0; nsrEnd0 <= 1'b0; nsrEnd1 <= 1'b0; endSel <= 1'b0;
    end else begin
      if (stb.txDone) isrPt <= 1'b1;
      else if (wrIsr && wrData[1]) isrPt <= 1'b0;
      if (stb.txDone && !endSel) nsrEnd0 <= 1'b1;
      else if (wrNsr && wrData[2]) nsrEnd0 <= 1'b0;
      if (stb.txDone && endSel) nsrEnd1 <= 1'b1;
      else if (wrNsr && wrData[3]) nsrEnd1 <= 1'b0;
      if (stb.txDone) endSel <= !endSel;
    end
  end

  always_comb begin
    case (stb.idx)
      IDX_CTRL:  regByte = {7'b0, stb.rstBusy};
      IDX_NSTAT: regByte = {4'b0, nsrEnd1, nsrEnd0, 2'b0};
      IDX_TXCTL: regByte = {7'b0, stb.txBusy};
      IDX_VIDL:  regByte = VENDOR_ID[7:0];
      IDX_VIDH:  regByte = VENDOR_ID[15:8];
      IDX_PIDL:  regByte = 8'h00;
      IDX_PIDH:  regByte = 8'h90;
      IDX_PTRL:  regByte = 16'(ptr) >> 0;
      IDX_PTRH:  regByte = 8'(16'(ptr) >> 8);
      IDX_LENL:  regByte = lenLo;
      IDX_LENH:  regByte = lenHi;
      IDX_ISTAT: regByte = {busMode, isrOvf, 3'b0, isrPt, 1'b0};
      default:   regByte = 8'h00;
    endcase
    rdData = selData ? {24'b0, regByte} : {24'b0, stb.idx};
  end

  // R7
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.txStart |=> (ptr == '0));

  // R8
  pt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.txDone |=> isrPt);

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isrOvf && !(wrIsr && wrData[5]) && !stb.rstStart) |=> isrOvf);

  // R10
  len_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.rstStart |=> (lenLo == 8'h00 && lenHi == 8'h00));
endmodule

// File: rtl/ethIdxRegPort.sv
module ethIdxRegPort
  import ethIdxPkg::*;
#(
  parameter int          BUF_BYTES  = 64,
  parameter int          TX_DELAY   = 16,
  parameter int          RST_CYCLES = 1000,
  parameter logic [15:0] VENDOR_ID  = 16'h1F5C
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   busMode,
  input  logic                         wrEn,
  input  logic                         selData,
  input  logic [31:0]                  wrData,
  output logic [31:0]                  rdData,
  input  logic [$clog2(BUF_BYTES)-1:0] txRdAddr,
  output logic [7:0]                   txRdData
);
  strobe_t stb;

  ethIdxCtrl #(.TX_DELAY(TX_DELAY), .RST_CYCLES(RST_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .selData(selData),
    .wrByte(wrData[7:0]), .stb(stb)
  );

  ethIdxDatapath #(.BUF_BYTES(BUF_BYTES), .VENDOR_ID(VENDOR_ID)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busMode(busMode), .selData(selData),
    .wrData(wrData), .rdData(rdData), .txRdAddr(txRdAddr), .txRdData(txRdData)
  );
endmodule

// File: tb/tb_ethIdxRegPort.sv
`timescale 1ns/1ps
module tb_ethIdxRegPort;
  localparam int TXD  = 16;
  localparam int RSTC = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busMode = 2'b00;
  logic        wrEn = 1'b0;
  logic        selData = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [5:0]  txRdAddr = '0;
  logic [7:0]  txRdData;
  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ethIdxRegPort dut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .wrEn(wrEn), .selData(selData),
    .wrData(wrData), .rdData(rdData), .txRdAddr(txRdAddr), .txRdData(txRdData)
  );

  // {req[3:0], op[1:0] (0 write, 1 read), sel, data[31:0], expect[31:0]}
  localparam int NV = 28;
  localparam logic [70:0] VEC [NV] = '{
    {4'd2,  2'd0, 1'b0, 32'h28, 32'h0},       // R2
    {4'd2,  2'd1, 1'b1, 32'h0,  32'h5C},
    {4'd2,  2'd0, 1'b0, 32'h29, 32'h0},
    {4'd2,  2'd1, 1'b1, 32'h0,  32'h1F},
    {4'd2,  2'd0, 1'b0, 32'h2A, 32'h0},
    {4'd2,  2'd1, 1'b1, 32'h0,  32'h00},
    {4'd2,  2'd0, 1'b0, 32'h2B, 32'h0},
    {4'd2,  2'd1, 1'b1, 32'h0,  32'h90},
    {4'd1,  2'd1, 1'b0, 32'h0,  32'h2B},      // R1
    {4'd2,  2'd0, 1'b1, 32'h55, 32'h0},
    {4'd2,  2'd1, 1'b1, 32'h0,  32'h90},
    {4'd3,  2'd0, 1'b0, 32'hFE, 32'h0},       // R3
    {4'd3,  2'd1, 1'b1, 32'h0,  32'h00},
    {4'd6,  2'd0, 1'b0, 32'hFC, 32'h0},       // R6
    {4'd6,  2'd0, 1'b1, 32'hEE, 32'h0},
    {4'd6,  2'd1, 1'b1, 32'h0,  32'hEE},
    {4'd6,  2'd0, 1'b0, 32'hFD, 32'h0},
    {4'd6,  2'd0, 1'b1, 32'h05, 32'h0},
    {4'd6,  2'd1, 1'b1, 32'h0,  32'h05},
    {4'd11, 2'd0, 1'b0, 32'h40, 32'h0},       // R11
    {4'd11, 2'd0, 1'b1, 32'h77, 32'h0},
    {4'd11, 2'd1, 1'b1, 32'h0,  32'h00},
    {4'd4,  2'd0, 1'b0, 32'hF8, 32'h0},       // R4
    {4'd4,  2'd0, 1'b1, 32'hBBAA, 32'h0},
    {4'd4,  2'd0, 1'b1, 32'hDDCC, 32'h0},
    {4'd4,  2'd0, 1'b0, 32'hFA, 32'h0},
    {4'd4,  2'd1, 1'b1, 32'h0,  32'h04},
    {4'd1,  2'd1, 1'b0, 32'h0,  32'hFA}       // R1
  };

  task automatic wr(input logic sel, input logic [31:0] d);
    selData = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrIdx(input logic [7:0] i);
    wr(1'b0, {24'b0, i});
  endtask

  task automatic wrDat(input logic [31:0] d);
    wr(1'b1, d);
  endtask

  task automatic chk(input logic sel, input logic [31:0] exp, input string req);
    selData = sel;
    #1;
    nVec++;
    if (rdData !== exp) begin
      nBad++;
      $display("FAIL %s: rdData=%h expected %h", req, rdData, exp);
    end
  endtask

  task automatic chkBuf(input int a, input logic [7:0] exp, input string req);
    txRdAddr = 6'(a);
    #1;
    nVec++;
    if (txRdData !== exp) begin
      nBad++;
      $display("FAIL %s: buffer[%0d]=%h expected %h", req, a, txRdData, exp);
    end
  endtask

  task automatic rdReg(input logic [7:0] i, input logic [31:0] exp, input string req);
    wrIdx(i);
    chk(1'b1, exp, req);
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finishRun();
  end

  initial begin
    waitN(2);
    rstN = 1'b1;
    waitN(1);
    // R1 reset state: index 0x00, control bits clear
    chk(1'b0, 32'h00, "R1");
    chk(1'b1, 32'h00, "R10");
    rdReg(8'h01, 32'h00, "R8");
    rdReg(8'hFE, 32'h00, "R9");

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][66:65] == 2'd0) wr(VEC[v][64], VEC[v][63:32]);
      else chk(VEC[v][64], VEC[v][31:0], $sformatf("R%0d vec %0d", VEC[v][70:67], v));
    end

    // R4 16-bit stream contents
    chkBuf(0, 8'hAA, "R4"); chkBuf(1, 8'hBB, "R4");
    chkBuf(2, 8'hCC, "R4"); chkBuf(3, 8'hDD, "R4");

    // R3 / R4 32-bit mode
    busMode = 2'b01;
    rdReg(8'hFE, 32'h40, "R3");
    wrIdx(8'hF8); wrDat(32'h44332211);
    rdReg(8'hFA, 32'h08, "R4");
    rdReg(8'hFB, 32'h00, "R4");
    chkBuf(4, 8'h11, "R4"); chkBuf(7, 8'h44, "R4");
    // R3 / R4 8-bit mode and code 11
    busMode = 2'b10;
    rdReg(8'hFE, 32'h80, "R3");
    wrIdx(8'hF8); wrDat(32'h99);
    busMode = 2'b11;
    wrDat(32'hF05A);
    rdReg(8'hFA, 32'h0A, "R4");
    chkBuf(8, 8'h99, "R4"); chkBuf(9, 8'h5A, "R4");

    // R5 wrap and overflow
    busMode = 2'b01;
    wrIdx(8'hF8);
    for (int k = 0; k < 13; k++) wrDat(32'h0);
    rdReg(8'hFE, 32'h40, "R5");
    wrIdx(8'hF8); wrDat(32'hA3A2A1A0);
    rdReg(8'hFA, 32'h02, "R5");
    chkBuf(62, 8'hA0, "R5"); chkBuf(63, 8'hA1, "R5");
    chkBuf(0, 8'hA2, "R5"); chkBuf(1, 8'hA3, "R5");
    rdReg(8'hFE, 32'h60, "R5");
    // R9 write 0 keeps, write 1 clears
    wrDat(32'h00); chk(1'b1, 32'h60, "R9");
    wrDat(32'h20); chk(1'b1, 32'h40, "R9");
    busMode = 2'b00;

    // R7 send busy window
    wrIdx(8'h02); wrDat(32'h1);
    chk(1'b1, 32'h01, "R7");
    waitN(TXD - 1);
    chk(1'b1, 32'h01, "R7");
    waitN(1);
    chk(1'b1, 32'h00, "R7");
    rdReg(8'hFA, 32'h00, "R7");
    // R8 first completion
    rdReg(8'h01, 32'h04, "R8");
    rdReg(8'hFE, 32'h02, "R8");
    wrIdx(8'h02); wrDat(32'h1);
    waitN(TXD);
    rdReg(8'h01, 32'h0C, "R8");
    // R9 status clears
    wrDat(32'h04); chk(1'b1, 32'h08, "R9");
    wrIdx(8'hFE); wrDat(32'h02); chk(1'b1, 32'h00, "R9");

    // R10 soft reset
    wrIdx(8'hFC); wrDat(32'h33);
    wrIdx(8'h00); wrDat(32'h1);
    chk(1'b1, 32'h01, "R10");
    wrIdx(8'hFC); wrDat(32'h12);
    chk(1'b1, 32'h00, "R10");
    wrIdx(8'h00);
    waitN(RSTC - 4);
    chk(1'b1, 32'h01, "R10");
    waitN(1);
    chk(1'b1, 32'h00, "R10");
    rdReg(8'h01, 32'h00, "R10");

    finishRun();
  end
endmodule